// File: doc/BRIEF.md
# Dual-Slope Integrating Converter Sequencer

This block is the digital half of a dual-slope integrating analog-to-digital converter. When a conversion is requested, it closes the input switch so the integrator charges from the unknown voltage. It holds that switch for a fixed number of clock cycles, the run-up length T. It then opens the input switch and closes the reference switch, which drives the integrator back toward zero with a reference of opposite sign.

At that hand-over the same counter restarts from zero. It counts reference cycles until the external comparator reports that the integrator output has reached or passed zero. That count, taken against T, is the conversion result: with an ideal integrator it approaches T·Vin/Vref. If no crossing arrives in time, the result is clamped to the top code and an out-of-range flag is raised.

After either ending, the block pulses an integrator discharge for a fixed number of cycles. It then raises a one-cycle completion strobe and returns to waiting. The integrator and comparator themselves are analog and outside the block.

Top module: `dual_slope_adc_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, selInput, selRef, intReset, busy, done and overRange are 0 and result is 0.
- R2: A startReq sampled high while idle raises selInput from the next clock edge. selInput then stays high for exactly T = 2^RES_BITS cycles, with selRef and intReset low.
- R3: At most one of selInput, selRef and intReset is high in any cycle.
- R4: selRef rises in the cycle after selInput falls and stays high until the run-down ends. The result is the number of selRef cycles up to and including the first one in which cmpZero is sampled high. With an ideal integrator, this is the smallest k ≥ 1 such that T·Vin − k·Vref ≤ 0. Such an ending clears overRange.
- R5: If cmpZero has not been sampled high by the 2T-th selRef cycle, the run-down ends there. result becomes all ones (2T−1) and overRange becomes 1. A crossing sampled in the 2T-th cycle itself also gives this out-of-range ending.
- R6: When the run-down ends, intReset is high for exactly RST_CYCLES cycles. done is then high for exactly one cycle, after which the block is idle.
- R7: busy is high from the edge that accepts a start until intReset falls. It is low while idle and while done is high.
- R8: startReq is ignored while busy or while done is high. It neither restarts nor lengthens any phase nor alters the result.
- R9: result and overRange change only at the end of a run-down and hold their values at all other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| startReq | input | 1 | Conversion request, sampled while idle |
| cmpZero | input | 1 | Comparator: integrator output at or below zero |
| selInput | output | 1 | Connect input voltage to integrator (run-up) |
| selRef | output | 1 | Connect opposite-sign reference to integrator (run-down) |
| intReset | output | 1 | Discharge integrator |
| busy | output | 1 | Conversion in progress |
| done | output | 1 | One-cycle completion strobe |
| overRange | output | 1 | Last conversion found no crossing within 2T cycles |
| result | output | RES_BITS+1 | Reference-cycle count of the last conversion |

## Verification
The bench builds the block with RES_BITS = 4, which gives T = 16 and a 32-cycle run-down limit, and with RST_CYCLES = 3. These values make both the largest in-range count (31) and the saturated out-of-range ending reachable within a few dozen cycles each.

A behavioural integrator accumulates Vin during selInput and subtracts Vref during selRef. This lets input and reference ratios drive the comparator, including a zero input (count 1), full-scale equality (count T) and the one-code boundary between 31 and overrange. Start requests are also injected during every phase of one conversion to show they have no effect.

// File: rtl/dsadc_pkg.sv
package dsadc_pkg;

  typedef enum logic [2:0] {
    ST_IDLE     = 3'd0,
    ST_RUN_UP   = 3'd1,
    ST_RUN_DOWN = 3'd2,
    ST_DISCHG   = 3'd3,
    ST_DONE     = 3'd4
  } phase_e;

  typedef struct packed {
    logic cntClear;
    logic cntInc;
    logic latchCount;
    logic latchSat;
  } dp_strobe_t;

endpackage

// File: rtl/dsadc_datapath.sv
module dsadc_datapath
  import dsadc_pkg::*;
#(
  parameter int RES_BITS   = 8,
  parameter int RST_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  dp_strobe_t          strb,
  output logic                atUpEnd,
  output logic                atTimeout,
  output logic                atDischgEnd,
  output logic [RES_BITS:0]   result,
  output logic                overRange
);
  localparam int RES_W      = RES_BITS + 1;
  localparam int RUNUP_LEN  = 1 << RES_BITS;
  localparam int DOWN_LIMIT = 2 * RUNUP_LEN;

  logic [RES_W-1:0] phaseCnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phaseCnt <= '0;
    end else if (strb.cntClear) begin
      phaseCnt <= '0;
    end else if (strb.cntInc) begin
      phaseCnt <= phaseCnt + 1'b1;
    end
  end

  assign atUpEnd     = (phaseCnt == RES_W'(RUNUP_LEN - 1));
  assign atTimeout   = (phaseCnt == RES_W'(DOWN_LIMIT - 1));
  assign atDischgEnd = (phaseCnt == RES_W'(RST_CYCLES - 1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      result    <= '0;
      overRange <= 1'b0;
    end else if (strb.latchSat) begin
      result    <= '1;
      overRange <= 1'b1;
    end else if (strb.latchCount) begin
      result    <= phaseCnt + 1'b1;
      overRange <= 1'b0;
    end
  end

  // R9: the result register moves only on a latch strobe
  p_result_hold_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !(strb.latchCount || strb.latchSat) |=> $stable(result) && $stable(overRange));

  // R5: the out-of-range flag always comes with a saturated code
  p_sat_code_r5: assert property (@(posedge clk) disable iff (!rst_n)
    overRange |-> (result == '1));

  // R5: the counter is never stepped past the run-down limit
  p_cnt_no_wrap_r5: assert property (@(posedge clk) disable iff (!rst_n)
    strb.cntInc |-> !atTimeout);

endmodule

// File: rtl/dsadc_control.sv
module dsadc_control
  import dsadc_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       startReq,
  input  logic       cmpZero,
  input  logic       atUpEnd,
  input  logic       atTimeout,
  input  logic       atDischgEnd,
  output dp_strobe_t strb,
  output logic       selInput,
  output logic       selRef,
  output logic       intReset,
  output logic       busy,
  output logic       done
);
  phase_e phase, phaseNext;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase <= ST_IDLE;
    else        phase <= phaseNext;
  end

  always_comb begin
    phaseNext = phase;
    strb      = '0;
    unique case (phase)
      ST_IDLE: begin
        if (startReq) begin
          phaseNext     = ST_RUN_UP;
          strb.cntClear = 1'b1;
        end
      end
      ST_RUN_UP: begin
        if (atUpEnd) begin
          phaseNext     = ST_RUN_DOWN;
          strb.cntClear = 1'b1;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_RUN_DOWN: begin
        if (atTimeout) begin
          phaseNext     = ST_DISCHG;
          strb.latchSat = 1'b1;
          strb.cntClear = 1'b1;
        end else if (cmpZero) begin
          phaseNext       = ST_DISCHG;
          strb.latchCount = 1'b1;
          strb.cntClear   = 1'b1;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_DISCHG: begin
        if (atDischgEnd) begin
          phaseNext = ST_DONE;
        end else begin
          strb.cntInc = 1'b1;
        end
      end
      ST_DONE: phaseNext = ST_IDLE;
      default: phaseNext = ST_IDLE;
    endcase
  end

  assign selInput = (phase == ST_RUN_UP);
  assign selRef   = (phase == ST_RUN_DOWN);
  assign intReset = (phase == ST_DISCHG);
  assign done     = (phase == ST_DONE);
  assign busy     = selInput | selRef | intReset;

  // R3: switch selects never overlap
  p_sel_onehot_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({selInput, selRef, intReset}));

  // R4: reference phase follows run-up directly
  p_ref_after_up_r4: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(selInput) |-> selRef);

  // R6: completion strobe is a single cycle preceded by discharge
  p_done_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  p_dischg_before_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(intReset));

  // R8: no new run-up can begin unless the block was idle
  p_start_ignored_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy || done) |=> !$rose(selInput));

endmodule

// File: rtl/dual_slope_adc_ctrl.sv
module dual_slope_adc_ctrl
  import dsadc_pkg::*;
#(
  parameter int RES_BITS   = 8,
  parameter int RST_CYCLES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                startReq,
  input  logic                cmpZero,
  output logic                selInput,
  output logic                selRef,
  output logic                intReset,
  output logic                busy,
  output logic                done,
  output logic                overRange,
  output logic [RES_BITS:0]   result
);
  dp_strobe_t strb;
  logic       atUpEnd;
  logic       atTimeout;
  logic       atDischgEnd;

  dsadc_control u_control (
    .clk         (clk),
    .rst_n       (rst_n),
    .startReq    (startReq),
    .cmpZero     (cmpZero),
    .atUpEnd     (atUpEnd),
    .atTimeout   (atTimeout),
    .atDischgEnd (atDischgEnd),
    .strb        (strb),
    .selInput    (selInput),
    .selRef      (selRef),
    .intReset    (intReset),
    .busy        (busy),
    .done        (done)
  );

  dsadc_datapath #(
    .RES_BITS   (RES_BITS),
    .RST_CYCLES (RST_CYCLES)
  ) u_datapath (
    .clk         (clk),
    .rst_n       (rst_n),
    .strb        (strb),
    .atUpEnd     (atUpEnd),
    .atTimeout   (atTimeout),
    .atDischgEnd (atDischgEnd),
    .result      (result),
    .overRange   (overRange)
  );

endmodule

// File: tb/tb_dual_slope_adc_ctrl.sv
module tb_dual_slope_adc_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int RES_BITS   = 4;
  localparam int RST_CYCLES = 3;
  localparam int T          = 1 << RES_BITS;
  localparam int LIMIT      = 2 * T;
  localparam int WATCHDOG   = 20000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic startReq = 1'b0;
  logic cmpZero = 1'b1;
  logic selInput, selRef, intReset, busy, done, overRange;
  logic [RES_BITS:0] result;

  int compared = 0;
  int mismatched = 0;
  int cycles = 0;
  bit finished = 0;

  // reference model state
  int mMode = 0;  // 0 idle, 1 up, 2 down, 3 discharge, 4 done
  int mCnt = 0;
  int mRes = 0;
  int mOv = 0;

  // behavioural integrator
  int acc = 0;
  int vIn = 0;
  int vRef = 1;

  dual_slope_adc_ctrl #(.RES_BITS(RES_BITS), .RST_CYCLES(RST_CYCLES)) dut (
    .clk(clk), .rst_n(rst_n), .startReq(startReq), .cmpZero(cmpZero),
    .selInput(selInput), .selRef(selRef), .intReset(intReset), .busy(busy),
    .done(done), .overRange(overRange), .result(result)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input int act, input int exp, input string what);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s %s actual=%0d expected=%0d t=%0t", req, what, act, exp, $time);
    end
  endtask

  // model update at the active edge
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mMode = 0; mCnt = 0; mRes = 0; mOv = 0;
    end else begin
      case (mMode)
        0: if (startReq) begin mMode = 1; mCnt = 0; end
        1: if (mCnt == T - 1) begin mMode = 2; mCnt = 0; end else mCnt++;
        2: begin
          if (mCnt == LIMIT - 1) begin
            mRes = LIMIT - 1; mOv = 1; mMode = 3; mCnt = 0;
          end else if (cmpZero) begin
            mRes = mCnt + 1; mOv = 0; mMode = 3; mCnt = 0;
          end else mCnt++;
        end
        3: if (mCnt == RST_CYCLES - 1) mMode = 4; else mCnt++;
        default: mMode = 0;
      endcase
    end
  end

  // per-cycle comparison, then integrator update
  always @(negedge clk) begin
    if (rst_n && !finished) begin
      check("R2", int'(selInput), int'(mMode == 1), "selInput");
      check("R4", int'(selRef),   int'(mMode == 2), "selRef");
      check("R6", int'(intReset), int'(mMode == 3), "intReset");
      check("R6", int'(done),     int'(mMode == 4), "done");
      check("R7", int'(busy),     int'(mMode >= 1 && mMode <= 3), "busy");
      check("R9", int'(result),   mRes, "result");
      check("R5", int'(overRange), mOv, "overRange");
      check("R3", int'(selInput) + int'(selRef) + int'(intReset) <= 1, 1, "select overlap");
    end
    if (intReset)      acc = 0;
    else if (selInput) acc = acc + vIn;
    else if (selRef)   acc = acc - vRef;
    cmpZero = (acc <= 0);
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG && !finished) begin
      finished = 1;
      mismatched++;
      compared++;
      $display("FAIL watchdog expired actual=%0d expected<=%0d", cycles, WATCHDOG);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  function automatic int idealCount(input int vi, input int vr);
    int k = 1;
    while (T * vi - k * vr > 0 && k < LIMIT) k++;
    return k;
  endfunction

  // one conversion; noisy pulses startReq throughout to exercise R8
  task automatic convert(input int vi, input int vr, input bit noisy);
    int k, upCycles, n;
    bit expOv;
    vIn = vi; vRef = vr;
    k = idealCount(vi, vr);
    expOv = (k >= LIMIT);
    @(negedge clk) startReq = 1'b1;
    @(negedge clk);
    upCycles = 0; n = 0;
    while (!done) begin
      startReq = noisy && (n % 2 == 0);
      if (selInput) upCycles++;
      n++;
      @(negedge clk);
    end
    startReq = noisy;  // request while done is high
    check(noisy ? "R8" : "R2", upCycles, T, "run-up length");
    if (expOv) begin
      check("R5", int'(result), LIMIT - 1, "saturated result");
      check("R5", int'(overRange), 1, "overrange flag");
    end else begin
      check(noisy ? "R8" : "R4", int'(result), k, "count vs ideal");
      check("R4", int'(overRange), 0, "overrange clear");
    end
    @(negedge clk) startReq = 1'b0;
    check("R8", int'(busy), 0, "no restart after done");
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", int'({selInput, selRef, intReset, busy, done, overRange}), 0, "flags in reset");
    check("R1", int'(result), 0, "result in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1", int'({selInput, selRef, intReset, busy, done, overRange}), 0, "flags after reset");
    convert(8, 8, 0);    // equal input and reference: T
    convert(3, 8, 0);    // 6
    convert(5, 8, 1);    // 10, start requests ignored
    convert(0, 8, 0);    // zero input: 1
    convert(32, 16, 0);  // exactly 2T: overrange
    convert(31, 16, 0);  // 31, largest in-range count, clears flag
    convert(7, 1, 0);    // far overrange
    convert(1, 16, 0);   // 1
    repeat (4) @(negedge clk);
    check("R9", int'(result), 1, "result holds while idle");
    if (!finished) begin
      finished = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule